// File: doc/BRIEF.md
# Bus Wake-Up Pattern Detector

This block decides when bus activity should wake a transceiver that is resting in its low-power offline state. It takes the receive level from the differential bus. A low level means dominant and a high level means recessive. The level first passes through a synchronizer. The block then looks for three phases in turn: a dominant phase, a recessive phase and a second dominant phase. Each phase must last at least its own minimum number of clock cycles. The whole sequence must finish inside a bounded window.

Short glitches shorter than a phase minimum never move the sequence forward. Extra pulses that fall between qualified phases are tolerated. When the third phase qualifies in time, a sticky wake flag is set and the low-active receive output goes low. The flag stays set until offline mode is left or a clear strobe arrives. Leaving offline mode also returns every counter to its starting state.

The phase minimums and the window length are parameters counted in clock cycles. The window must be longer than the sum of the three phase minimums.

Top module: `bus_wake_detector`

## Requirements
- R1: After reset the wake flag is 0 and the low-active receive output `rxd_n_o` is 1.
- R2: Input level 0 on `bus_rx_i` is dominant and level 1 is recessive. The input passes through a two-flop synchronizer before any phase counting. A run of N input cycles therefore becomes a run of exactly N counted cycles.
- R3: A dominant run shorter than `DOM_MIN` cycles never qualifies, either as the first phase or as the third phase. A run of exactly `DOM_MIN` cycles does qualify.
- R4: A recessive run shorter than `REC_MIN` cycles never qualifies as the middle phase.
- R5: A qualified dominant, recessive, dominant sequence inside the window sets the wake flag and drives `rxd_n_o` low.
- R6: The span is counted from the first cycle of the first dominant run to the cycle in which the second dominant run reaches `DOM_MIN`. A span of `TIMEOUT` cycles wakes. A span of `TIMEOUT`+1 cycles does not.
- R7: When the window expires, the detector returns to idle. A dominant run still in progress at that moment does not count as a new first phase. Only a fresh dominant run that reaches `DOM_MIN` starts a new attempt.
- R8: Dominant or recessive pulses shorter than a minimum that occur between qualified phases do not cancel a sequence in progress.
- R9: The wake flag is sticky. A one-cycle `wake_clr_i` strobe clears it in the following cycle and returns `rxd_n_o` to 1.
- R10: While `offline_en_i` is 0, no pattern is detected. The flag is cleared in the following cycle and all counters restart.
- R11: The parameters must satisfy `TIMEOUT` > 2*`DOM_MIN` + `REC_MIN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| offline_en_i | input | 1 | High while the transceiver is in the offline state |
| bus_rx_i | input | 1 | Raw bus receive level, 0 dominant, 1 recessive |
| wake_clr_i | input | 1 | One-cycle strobe that clears the wake flag |
| wake_flag_o | output | 1 | Sticky wake flag |
| rxd_n_o | output | 1 | Low-active wake indication on the receive output |

## Verification
The hardest situation to reach from the ports is the window edge. It arises when a first dominant phase runs straight through the window expiry, and when the sequence completes on exactly the last permitted cycle. The stimulus builds exact-length runs at the input; the synchronizer preserves run lengths, so the span can be set to `TIMEOUT` or `TIMEOUT`+1 by stretching the recessive phase by one cycle. A separate scenario holds the bus dominant past expiry and then plays a short recessive and dominant pair. This shows that the stale run is not reused as a first phase.

// File: rtl/wk_pkg.sv
package wk_pkg;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_DOM1 = 2'd1,
        WK_REC  = 2'd2,
        WK_DONE = 2'd3
    } wk_state_e;

endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_regs_t;

    sync_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!enable_i) begin
            r_d.chain = '1;
        end else begin
            r_d.chain = {r_q.chain[STAGES-2:0], async_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{chain: '1};
        else        r_q <= r_d;
    end

    assign sync_o = r_q.chain[STAGES-1];
endmodule

// File: rtl/wk_run_timer.sv
module wk_run_timer #(
    parameter int DOM_MIN = 50,
    parameter int REC_MIN = 50,
    parameter int CNT_MAX = 1000,
    parameter int CNT_W   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic dom_i,
    output logic dom_qual_o,
    output logic rec_qual_o
);
    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } run_regs_t;

    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] DOM_LIM = CNT_W'(DOM_MIN);
    localparam logic [CNT_W-1:0] REC_LIM = CNT_W'(REC_MIN);

    run_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!enable_i) begin
            r_d = '0;
        end else if (dom_i == r_q.lvl) begin
            if (r_q.cnt != CNT_TOP) r_d.cnt = r_q.cnt + 1'b1;
        end else begin
            r_d.lvl = dom_i;
            r_d.cnt = CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dom_qual_o = enable_i &&  dom_i && (r_d.cnt == DOM_LIM);
    assign rec_qual_o = enable_i && !dom_i && (r_d.cnt == REC_LIM);
endmodule

// File: rtl/wk_seq_fsm.sv
module wk_seq_fsm
    import wk_pkg::*;
#(
    parameter int DOM_MIN = 50,
    parameter int TIMEOUT = 1000,
    parameter int CNT_W   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic clr_i,
    input  logic dom_qual_i,
    input  logic rec_qual_i,
    output logic wake_o
);
    typedef struct packed {
        wk_state_e        state;
        logic [CNT_W-1:0] win;
        logic             flag;
    } fsm_regs_t;

    localparam logic [CNT_W-1:0] WIN_START = CNT_W'(DOM_MIN);
    localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(TIMEOUT);

    fsm_regs_t        r_d, r_q;
    logic [CNT_W-1:0] win_next;
    logic             expire;

    assign win_next = r_q.win + 1'b1;
    assign expire   = (win_next >= WIN_LAST);

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            WK_IDLE: begin
                if (dom_qual_i) begin
                    r_d.state = WK_DOM1;
                    r_d.win   = WIN_START;
                end
            end
            WK_DOM1: begin
                r_d.win = win_next;
                if (expire) begin
                    r_d.state = dom_qual_i ? WK_DOM1 : WK_IDLE;
                    r_d.win   = dom_qual_i ? WIN_START : '0;
                end else if (rec_qual_i) begin
                    r_d.state = WK_REC;
                end
            end
            WK_REC: begin
                r_d.win = win_next;
                if (dom_qual_i) begin
                    r_d.state = WK_DONE;
                    r_d.flag  = 1'b1;
                end else if (expire) begin
                    r_d.state = WK_IDLE;
                    r_d.win   = '0;
                end
            end
            WK_DONE: begin
                r_d.flag = 1'b1;
            end
            default: r_d = '0;
        endcase
        if (clr_i) begin
            r_d.state = WK_IDLE;
            r_d.win   = '0;
            r_d.flag  = 1'b0;
        end
        if (!enable_i) r_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wake_o = r_q.flag;
endmodule

// File: rtl/bus_wake_detector.sv
module bus_wake_detector #(
    parameter int DOM_MIN     = 50,
    parameter int REC_MIN     = 50,
    parameter int TIMEOUT     = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic offline_en_i,
    input  logic bus_rx_i,
    input  logic wake_clr_i,
    output logic wake_flag_o,
    output logic rxd_n_o
);
    localparam int CNT_W = $clog2(TIMEOUT + 2);

    logic bus_sync;
    logic dom_s;
    logic dom_qual;
    logic rec_qual;
    logic wake;

    wk_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (offline_en_i),
        .async_i  (bus_rx_i),
        .sync_o   (bus_sync)
    );

    assign dom_s = ~bus_sync;

    wk_run_timer #(
        .DOM_MIN (DOM_MIN),
        .REC_MIN (REC_MIN),
        .CNT_MAX (TIMEOUT),
        .CNT_W   (CNT_W)
    ) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (offline_en_i),
        .dom_i      (dom_s),
        .dom_qual_o (dom_qual),
        .rec_qual_o (rec_qual)
    );

    wk_seq_fsm #(
        .DOM_MIN (DOM_MIN),
        .TIMEOUT (TIMEOUT),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (offline_en_i),
        .clr_i      (wake_clr_i),
        .dom_qual_i (dom_qual),
        .rec_qual_i (rec_qual),
        .wake_o     (wake)
    );

    assign wake_flag_o = wake;
    assign rxd_n_o     = ~wake;
endmodule

// File: rtl/bus_wake_detector_chk.sv
module bus_wake_detector_chk #(
    parameter int DOM_MIN = 50,
    parameter int REC_MIN = 50,
    parameter int TIMEOUT = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic offline_en_i,
    input logic wake_clr_i,
    input logic wake_flag_o,
    input logic rxd_n_o
);
    initial begin
        a_r11_window_fits: assert (TIMEOUT > 2 * DOM_MIN + REC_MIN);
    end

    a_r10_offline_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !offline_en_i |=> !wake_flag_o);

    a_r10_rise_needs_offline: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag_o) |-> $past(offline_en_i));

    a_r9_clear_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wake_clr_i |=> !wake_flag_o);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag_o && offline_en_i && !wake_clr_i) |=> wake_flag_o);

    a_r5_rxd_low_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag_o) |-> $fell(rxd_n_o));
endmodule

bind bus_wake_detector bus_wake_detector_chk #(
    .DOM_MIN (DOM_MIN),
    .REC_MIN (REC_MIN),
    .TIMEOUT (TIMEOUT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .offline_en_i (offline_en_i),
    .wake_clr_i   (wake_clr_i),
    .wake_flag_o  (wake_flag_o),
    .rxd_n_o      (rxd_n_o)
);

// File: tb/test_bus_wake_detector.sv
module test_bus_wake_detector;
    localparam int DOM = 5;
    localparam int REC = 6;
    localparam int TO  = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic offline_en = 1'b0;
    logic bus_rx = 1'b1;
    logic wake_clr = 1'b0;
    logic wake_flag;
    logic rxd_n;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bus_wake_detector #(
        .DOM_MIN (DOM),
        .REC_MIN (REC),
        .TIMEOUT (TO)
    ) i_bus_wake_detector (
        .clk          (clk),
        .rst_n        (rst_n),
        .offline_en_i (offline_en),
        .bus_rx_i     (bus_rx),
        .wake_clr_i   (wake_clr),
        .wake_flag_o  (wake_flag),
        .rxd_n_o      (rxd_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_wake(input string req, input bit exp);
        check(wake_flag == exp, {req, " flag"}, wake_flag, exp);
        check(rxd_n == !exp, {req, " rxd_n"}, rxd_n, !exp);
    endtask

    task automatic hold(input logic lvl, input int n);
        bus_rx = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic restart();
        offline_en = 1'b0;
        bus_rx = 1'b1;
        repeat (2) @(negedge clk);
        offline_en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pattern(input int d1, input int r, input int d2);
        hold(1'b0, d1);
        hold(1'b1, r);
        hold(1'b0, d2);
        hold(1'b1, 8);
    endtask

    task automatic t_reset();
        expect_wake("R1", 1'b0);
    endtask

    task automatic t_basic();
        restart();
        pattern(DOM, REC, DOM);
        expect_wake("R5", 1'b1);
        hold(1'b1, 20);
        expect_wake("R9 sticky", 1'b1);
    endtask

    task automatic t_short_phases();
        restart();
        pattern(DOM - 1, REC, DOM);
        expect_wake("R3 short first", 1'b0);
        restart();
        pattern(DOM, REC - 1, DOM);
        expect_wake("R4 short middle", 1'b0);
        restart();
        pattern(DOM, REC, DOM - 1);
        expect_wake("R3 short third", 1'b0);
        restart();
        pattern(DOM, REC, DOM);
        expect_wake("R2 R3 exact minimums", 1'b1);
    endtask

    task automatic t_window();
        restart();
        pattern(DOM, TO - 2 * DOM, DOM);
        expect_wake("R6 span equals window", 1'b1);
        restart();
        pattern(DOM, TO - 2 * DOM + 1, DOM);
        expect_wake("R6 span one over", 1'b0);
    endtask

    task automatic t_stale_run();
        restart();
        hold(1'b0, TO + 20);
        hold(1'b1, REC);
        hold(1'b0, DOM);
        hold(1'b1, 8);
        expect_wake("R7 stale dominant", 1'b0);
        restart();
        hold(1'b0, DOM);
        hold(1'b1, TO + 5);
        pattern(DOM, REC, DOM);
        expect_wake("R7 new attempt after expiry", 1'b1);
    endtask

    task automatic t_extra_pulses();
        restart();
        hold(1'b0, DOM);
        hold(1'b1, 2);
        hold(1'b0, 1);
        hold(1'b1, REC + 2);
        hold(1'b0, 1);
        hold(1'b1, 2);
        hold(1'b0, DOM);
        hold(1'b1, 8);
        expect_wake("R8 extra pulses", 1'b1);
    endtask

    task automatic t_clear();
        restart();
        pattern(DOM, REC, DOM);
        expect_wake("R9 before clear", 1'b1);
        wake_clr = 1'b1;
        @(negedge clk);
        wake_clr = 1'b0;
        expect_wake("R9 cleared", 1'b0);
    endtask

    task automatic t_offline();
        restart();
        offline_en = 1'b0;
        pattern(DOM, REC, DOM);
        expect_wake("R10 not offline", 1'b0);
        offline_en = 1'b1;
        repeat (4) @(negedge clk);
        pattern(DOM, REC, DOM);
        expect_wake("R10 woke", 1'b1);
        offline_en = 1'b0;
        @(negedge clk);
        expect_wake("R10 leave clears", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_short_phases();
        t_window();
        t_stale_run();
        t_extra_pulses();
        t_clear();
        t_offline();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule